// File: doc/BRIEF.md
# PC-Relative Operand Address Generator

This unit turns the address of the executing instruction into the values that instruction sees when it uses the program counter. The processor it serves has two instruction modes. One is a fixed-width mode with 32-bit instructions only. The other is a compact mode that mixes 16-bit and 32-bit instructions on halfword boundaries.

For each request the unit forms up to three values:
- The visible PC value, which is what an ordinary register read of the PC returns.
- The effective address of a PC-relative load, store or address-forming operation. Its base is the visible PC with its two low bits cleared, plus a signed 13-bit immediate.
- The link address for the first half of a legacy two-halfword branch-with-link.

The instruction-size flag is accepted at the port but never changes any result. In compact mode the PC always reads four bytes ahead, whatever the length of the instruction.

A single register stage captures the results whenever `in_valid` is high and holds them until the next valid request. An instruction address that breaks the alignment rule of its mode raises an error flag instead of a valid result.

Top module: `pcrel_agu`

## Requirements
- R1: With `compact_mode`=0, `out_pcread` equals `instr_addr` + 8.
- R2: With `compact_mode`=1, `out_pcread` equals `instr_addr` + 4. The `wide_instr` input (1 = 32-bit instruction) has no effect on any output.
- R3: For `op_class` 1 (memory access) or 2 (address forming), `out_result` equals the visible PC with bits 1:0 cleared, plus the sign-extended immediate.
- R4: For `op_class` 0 (register read), `out_result` equals the visible PC without alignment. For example, a compact instruction at 0x1598 gives 0x159C.
- R5: `imm_off` is a 13-bit two's-complement value, sign-extended to 32 bits. The result may be odd or halfword-aligned. For example, base 0x15A4 with offset -1 gives 0x15A3.
- R6: For `op_class` 3 (legacy link), `out_result` equals `instr_addr` + 4, which is the address just past the second halfword.
- R7: A misaligned address sets `out_err`=1 and `out_valid`=0 after the capturing edge, and leaves `out_pcread` and `out_result` unchanged. An address is misaligned if bit 0 is set in compact mode, or if bits 1:0 are nonzero in fixed mode. The next aligned valid request clears `out_err`.
- R8: All address arithmetic wraps modulo 2^32 and raises no flag.
- R9: Outputs change only on a clock edge where `in_valid`=1. They appear at the first rising edge after the request and hold while `in_valid`=0.
- R10: Synchronous active-low reset clears `out_valid` and `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; inputs are captured when high |
| instr_addr | input | 32 | Address of the executing instruction |
| compact_mode | input | 1 | 1 = mixed 16/32-bit mode, 0 = fixed 32-bit mode |
| wide_instr | input | 1 | 1 = 32-bit instruction; ignored by design |
| imm_off | input | 13 | Signed immediate offset |
| op_class | input | 2 | 0 register read, 1 memory access, 2 address forming, 3 legacy link |
| out_valid | output | 1 | Registered result is valid |
| out_err | output | 1 | Last request was misaligned |
| out_pcread | output | 32 | Visible PC value for the captured request |
| out_result | output | 32 | Value selected by the captured operation class |

## Verification
Two values are produced in the same cycle for the same instruction: the unaligned visible PC and the aligned-base effective address. They are provoked together by a compact-mode instruction on an address ending in 2, such as 0x159A, which must show 0x159E on `out_pcread` and 0x159C on `out_result` at the same edge. The bench also judges that these two values diverge correctly around negative and wrapping offsets. A second collision is between the error flag and the result capture, which happen on the same edge. Sending a misaligned request right after a good one checks that the error rises, valid falls and the earlier data stays in place.

// File: rtl/pcrel_pkg.sv
// Package: shared encodings for the PC-relative address generator.
// Assumes op_class is a 2-bit field decoded by the instruction front end.
package pcrel_pkg;
    typedef enum logic [1:0] {
        OPC_READ = 2'd0,  // ordinary register read of the PC
        OPC_MEM  = 2'd1,  // PC-relative load or store
        OPC_FORM = 2'd2,  // PC-relative address forming
        OPC_LINK = 2'd3   // first half of legacy branch-with-link
    } opc_e;
endpackage

// File: rtl/pcrel_align_chk.sv
// Module: flags an instruction address that breaks its mode's alignment rule.
// Assumes compact-mode instructions sit on halfwords and fixed-mode on words.
module pcrel_align_chk #(
    parameter int ADDR_W   = 32,
    parameter int WORD_LSB = 2
) (
    input  logic              compact,
    input  logic [ADDR_W-1:0] addr,
    output logic              misaligned
);
    // Purpose: pick the low-bit mask for the current mode.
    always_comb begin
        if (compact) misaligned = addr[0];
        else         misaligned = |addr[WORD_LSB-1:0];
    end
endmodule

// File: rtl/pcrel_pcview.sv
// Module: computes the architecturally visible PC from the instruction address.
// Assumes the read-ahead distance depends on mode only, never on instruction size.
module pcrel_pcview #(
    parameter int ADDR_W        = 32,
    parameter int FIXED_AHEAD   = 8,
    parameter int COMPACT_AHEAD = 4
) (
    input  logic              compact,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] pc_read
);
    localparam logic [ADDR_W-1:0] FIX_INC = ADDR_W'(FIXED_AHEAD);
    localparam logic [ADDR_W-1:0] CMP_INC = ADDR_W'(COMPACT_AHEAD);

    // Purpose: add the mode's fixed read-ahead, wrapping modulo 2^ADDR_W.
    always_comb begin
        pc_read = addr + (compact ? CMP_INC : FIX_INC);
    end
endmodule

// File: rtl/pcrel_addr.sv
// Module: forms the aligned-base effective address, the link address and the
// class-selected result. Assumes pc_read comes from pcrel_pcview.
module pcrel_addr #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 13,
    parameter int WORD_LSB   = 2,
    parameter int LINK_AHEAD = 4
) (
    input  logic              [ADDR_W-1:0] pc_read,
    input  logic              [ADDR_W-1:0] instr_addr,
    input  logic              [IMM_W-1:0]  imm,
    input  pcrel_pkg::opc_e                opc,
    output logic              [ADDR_W-1:0] result
);
    import pcrel_pkg::*;
    localparam int EXT_W = ADDR_W - IMM_W;
    localparam logic [ADDR_W-1:0] LINK_INC = ADDR_W'(LINK_AHEAD);

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] link;

    // Purpose: sign-extend the offset and word-align the PC base.
    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        base    = {pc_read[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
        link    = instr_addr + LINK_INC;
    end

    // Purpose: select the value the operation class asks for.
    always_comb begin
        unique case (opc)
            OPC_READ: result = pc_read;
            OPC_MEM,
            OPC_FORM: result = base + imm_ext;
            OPC_LINK: result = link;
            default:  result = pc_read;
        endcase
    end
endmodule

// File: rtl/pcrel_agu.sv
// Module: top of the PC-relative operand address generator. Combines the
// alignment check, visible-PC view and address former, then registers results.
// Assumes requests arrive as single-cycle in_valid pulses or held levels.
module pcrel_agu #(
    parameter int ADDR_W        = 32,
    parameter int IMM_W         = 13,
    parameter int WORD_LSB      = 2,
    parameter int FIXED_AHEAD   = 8,
    parameter int COMPACT_AHEAD = 4,
    parameter int LINK_AHEAD    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic              compact_mode,
    input  logic              wide_instr,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [1:0]        op_class,
    output logic              out_valid,
    output logic              out_err,
    output logic [ADDR_W-1:0] out_pcread,
    output logic [ADDR_W-1:0] out_result
);
    import pcrel_pkg::*;
    localparam int EXT_W = ADDR_W - IMM_W;

    logic              misaligned;
    logic [ADDR_W-1:0] pc_read;
    logic [ADDR_W-1:0] result;
    opc_e              opc;
    logic              size_unused;

    // Purpose: the size flag is deliberately not used by any result.
    assign size_unused = wide_instr;
    assign opc         = opc_e'(op_class);

    pcrel_align_chk #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_align (
        .compact    (compact_mode),
        .addr       (instr_addr),
        .misaligned (misaligned)
    );

    pcrel_pcview #(.ADDR_W(ADDR_W), .FIXED_AHEAD(FIXED_AHEAD),
                   .COMPACT_AHEAD(COMPACT_AHEAD)) u_view (
        .compact (compact_mode),
        .addr    (instr_addr),
        .pc_read (pc_read)
    );

    pcrel_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .WORD_LSB(WORD_LSB),
                 .LINK_AHEAD(LINK_AHEAD)) u_addr (
        .pc_read    (pc_read),
        .instr_addr (instr_addr),
        .imm        (imm_off),
        .opc        (opc),
        .result     (result)
    );

    // Purpose: capture results on a valid request; errors keep the old data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            out_pcread <= '0;
            out_result <= '0;
        end else if (in_valid) begin
            out_err   <= misaligned;
            out_valid <= !misaligned;
            if (!misaligned) begin
                out_pcread <= pc_read;
                out_result <= result;
            end
        end
    end

    // Sign-extends an immediate for the checks below.
    function automatic logic [ADDR_W-1:0] sext(input logic [IMM_W-1:0] v);
        return {{EXT_W{v[IMM_W-1]}}, v};
    endfunction

    assert_fixed_ahead_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !compact_mode && !misaligned |=>
            out_pcread == $past(instr_addr) + ADDR_W'(FIXED_AHEAD));

    assert_compact_ahead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && compact_mode && !misaligned |=>
            out_pcread == $past(instr_addr) + ADDR_W'(COMPACT_AHEAD));

    assert_aligned_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !misaligned && (op_class == 2'd1 || op_class == 2'd2) |=>
            ((out_result - sext($past(imm_off))) & ADDR_W'(3)) == '0);

    assert_misalign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && misaligned |=> out_err && !out_valid && $stable(out_result));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_valid) && $stable(out_err)
                      && $stable(out_result) && $stable(out_pcread));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_err);
endmodule

// File: tb/tb_pcrel_agu.sv
`timescale 1ns/1ps
module tb_pcrel_agu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr_addr;
    logic        compact_mode;
    logic        wide_instr;
    logic [12:0] imm_off;
    logic [1:0]  op_class;
    logic        out_valid;
    logic        out_err;
    logic [31:0] out_pcread;
    logic [31:0] out_result;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pcrel_agu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_addr(instr_addr),
        .compact_mode(compact_mode), .wide_instr(wide_instr), .imm_off(imm_off),
        .op_class(op_class), .out_valid(out_valid), .out_err(out_err),
        .out_pcread(out_pcread), .out_result(out_result)
    );

    // Vector: {compact, wide, class, imm, addr, expected pcread, expected result}
    localparam int NV = 13;
    localparam logic [112:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd0, 13'd0,      32'h0000_1598, 32'h0000_159C, 32'h0000_159C}, // R2 R4
        {1'b1, 1'b1, 2'd1, 13'd0,      32'h0000_159A, 32'h0000_159E, 32'h0000_159C}, // R2 R3
        {1'b1, 1'b1, 2'd1, 13'h1FFF,   32'h0000_15A0, 32'h0000_15A4, 32'h0000_15A3}, // R5
        {1'b1, 1'b1, 2'd1, 13'h1FFC,   32'h0000_15AC, 32'h0000_15B0, 32'h0000_15AC}, // R5
        {1'b1, 1'b1, 2'd2, 13'h0338,   32'h0027_9AE6, 32'h0027_9AEA, 32'h0027_9E20}, // R3
        {1'b0, 1'b0, 2'd0, 13'd0,      32'h0000_1000, 32'h0000_1008, 32'h0000_1008}, // R1 R4
        {1'b0, 1'b0, 2'd1, 13'h0FFF,   32'h0000_2000, 32'h0000_2008, 32'h0000_3007}, // R1 R5
        {1'b0, 1'b0, 2'd2, 13'h1000,   32'h0000_2000, 32'h0000_2008, 32'h0000_1008}, // R5
        {1'b1, 1'b0, 2'd3, 13'd0,      32'h0000_4000, 32'h0000_4004, 32'h0000_4004}, // R6
        {1'b0, 1'b0, 2'd3, 13'd0,      32'h0000_4000, 32'h0000_4008, 32'h0000_4004}, // R6
        {1'b0, 1'b0, 2'd0, 13'd0,      32'hFFFF_FFFC, 32'h0000_0004, 32'h0000_0004}, // R8
        {1'b1, 1'b1, 2'd1, 13'd2,      32'hFFFF_FFFE, 32'h0000_0002, 32'h0000_0002}, // R8
        {1'b1, 1'b0, 2'd1, 13'd0,      32'h0000_159A, 32'h0000_159E, 32'h0000_159C}  // R2 size-blind
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive one request for one cycle; the result is sampled on the following negedge.
    task automatic send(input logic cm, input logic wd, input logic [1:0] oc,
                        input logic [12:0] im, input logic [31:0] a);
        @(negedge clk);
        compact_mode = cm; wide_instr = wd; op_class = oc; imm_off = im;
        instr_addr = a; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; instr_addr = '0; compact_mode = 1'b0;
        wide_instr = 1'b0; imm_off = '0; op_class = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R10 reset err", {31'd0, out_err}, 32'd0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][112], VEC[i][111], VEC[i][110:109], VEC[i][108:96], VEC[i][95:64]);
            chk($sformatf("R1/R2 table %0d pcread", i), out_pcread, VEC[i][63:32]);
            chk($sformatf("R3/R4/R5/R6/R8 table %0d result", i), out_result, VEC[i][31:0]);
            chk($sformatf("R9 table %0d valid", i), {31'd0, out_valid}, 32'd1);
        end

        // R2: the size flag alone toggled gives identical outputs
        send(1'b1, 1'b1, 2'd1, 13'h1FFF, 32'h0000_3002);
        chk("R2 wide pcread", out_pcread, 32'h0000_3006);
        chk("R2 wide result", out_result, 32'h0000_3003);
        send(1'b1, 1'b0, 2'd1, 13'h1FFF, 32'h0000_3002);
        chk("R2 narrow pcread", out_pcread, 32'h0000_3006);
        chk("R2 narrow result", out_result, 32'h0000_3003);

        // R7: compact odd address, data held from previous request
        send(1'b1, 1'b0, 2'd0, 13'd0, 32'h0000_1001);
        chk("R7 compact err", {31'd0, out_err}, 32'd1);
        chk("R7 compact valid", {31'd0, out_valid}, 32'd0);
        chk("R7 compact held result", out_result, 32'h0000_3003);
        chk("R7 compact held pcread", out_pcread, 32'h0000_3006);
        // R7: fixed mode on halfword address
        send(1'b0, 1'b0, 2'd1, 13'd4, 32'h0000_1002);
        chk("R7 fixed err", {31'd0, out_err}, 32'd1);
        chk("R7 fixed valid", {31'd0, out_valid}, 32'd0);
        // R7: compact halfword address is legal and clears the flag
        send(1'b1, 1'b0, 2'd1, 13'd4, 32'h0000_1002);
        chk("R7 recover err", {31'd0, out_err}, 32'd0);
        chk("R7 recover valid", {31'd0, out_valid}, 32'd1);
        chk("R7 recover result", out_result, 32'h0000_1008);

        // R9: idle cycles with changing inputs leave outputs alone
        @(negedge clk);
        instr_addr = 32'h0000_8000; op_class = 2'd3; compact_mode = 1'b0; imm_off = 13'h0123;
        repeat (3) @(negedge clk);
        chk("R9 hold result", out_result, 32'h0000_1008);
        chk("R9 hold pcread", out_pcread, 32'h0000_1006);
        chk("R9 hold valid", {31'd0, out_valid}, 32'd1);

        // R10: reset in the middle of operation, after an error
        send(1'b0, 1'b0, 2'd0, 13'd0, 32'h0000_0003);
        chk("R7 before reset err", {31'd0, out_err}, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset err", {31'd0, out_err}, 32'd0);
        chk("R10 mid reset valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule